// File: doc/BRIEF.md
# SCSI Interrupt Status Latch

This block turns SCSI bus events into sticky interrupt status bits that a host can read. Each status bit captures one condition: an unexpected target disconnect, a received bus reset, a receive parity error, a selection time-out, a general-purpose timer expiry or a handshake-to-handshake timer expiry. A bit stays set until the host reads its register, and an event that arrives in the same cycle as that read is kept. A per-bit enable mask decides which latched conditions drive the interrupt request. A status read still shows every latched condition, including the masked ones.

Whether a disconnect counts depends on the operating mode. In initiator mode only a disconnect that was not expected counts. In low-level mode every disconnect counts. In target mode no disconnect counts. A selection time-out also counts as an unexpected disconnect. The bus reset line is passed through a synchronizer and detected on its rising edge, so one reset produces one status event however long the line is held. The block also computes odd parity on outgoing bytes, whether or not receive checking is enabled.

Top module: `scsi_int_status`

## Requirements
- R1: After reset, both status registers, the enable mask and irq_o are all zero.
- R2: With initiator_i=1 and low_level_i=0, a disc_evt_i pulse with disc_expected_i=0 sets status0_o bit 2 on the next clock. With disc_expected_i=1 it leaves that bit clear.
- R3: With initiator_i=0 and low_level_i=0 (target mode), neither disc_evt_i nor sel_timeout_i ever sets status0_o bit 2.
- R4: With low_level_i=1, every disc_evt_i pulse sets status0_o bit 2, whatever disc_expected_i and initiator_i are.
- R5: A sel_timeout_i pulse sets status1_o bit 2 on the next clock in every mode. In the same clock it also sets status0_o bit 2 when initiator_i or low_level_i is 1.
- R6: The OR of bus_rst_raw_i and local_rst_i goes through a two-flop synchronizer. Its rising edge sets status0_o bit 1 on the third clock edge after the line is first sampled high. Holding the line high causes no further set after that bit is cleared.
- R7: When rx_strobe_i=1 and par_chk_en_i=1, status0_o bit 0 sets if rx_data_i together with rx_par_i holds an even number of ones (odd parity expected). The bit never sets while par_chk_en_i=0 or rx_strobe_i=0.
- R8: tx_par_o equals 1 exactly when tx_data_i holds an even number of ones, so that data plus parity is odd, independent of par_chk_en_i.
- R9: A gp_timer_i pulse sets status1_o bit 1 and an hth_timer_i pulse sets status1_o bit 0. Bits 7 to 3 of both status registers always read zero.
- R10: A one-cycle rd_stat0_i or rd_stat1_i strobe clears the matching status register on the next clock. An event in the same cycle as the strobe leaves its bit set. Status reads show bits whose enables are off.
- R11: mask_wr_i loads mask_wdata_i. Mask bit i enables status0_o bit i and mask bit 8+i enables status1_o bit i. irq_o is the OR of every latched status bit ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| initiator_i | input | 1 | 1 = acting as initiator, 0 = target |
| low_level_i | input | 1 | Low-level mode: every disconnect is reported |
| disc_evt_i | input | 1 | Pulse: target left the bus |
| disc_expected_i | input | 1 | Qualifies disc_evt_i as an expected disconnect |
| sel_timeout_i | input | 1 | Pulse: selection time-out |
| gp_timer_i | input | 1 | Pulse: general-purpose timer expired |
| hth_timer_i | input | 1 | Pulse: handshake-to-handshake timer expired |
| bus_rst_raw_i | input | 1 | Asynchronous bus reset line, active high |
| local_rst_i | input | 1 | Local control that asserts bus reset |
| rx_strobe_i | input | 1 | A received byte is valid |
| rx_data_i | input | 8 | Received byte |
| rx_par_i | input | 1 | Received parity bit |
| par_chk_en_i | input | 1 | Enables receive parity checking |
| tx_data_i | input | 8 | Byte to be transmitted |
| tx_par_o | output | 1 | Odd parity bit for tx_data_i |
| rd_stat0_i | input | 1 | Read strobe, clears status register 0 |
| rd_stat1_i | input | 1 | Read strobe, clears status register 1 |
| mask_wr_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 16 | Enable mask write data |
| status0_o | output | 8 | Status register 0: bit2 disconnect, bit1 bus reset, bit0 parity |
| status1_o | output | 8 | Status register 1: bit2 selection time-out, bit1 gp timer, bit0 hth timer |
| mask_o | output | 16 | Current enable mask |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the event inputs are one-cycle pulses sampled on the rising clock. They also assume that the mode flags are stable in the cycle an event is sampled, because the disconnect and time-out checks look at the mode one cycle back. The reset edge check assumes the bus reset line is still high three edges after it is first sampled. The stimulus drives every input on the falling edge, keeps each event high for exactly one cycle, and holds the bus reset line for many cycles once it is raised.

// File: rtl/scsi_ist_pkg.sv
package scsi_ist_pkg;
    localparam int unsigned ST_W = 8;

    // status register 0 bit positions
    localparam int unsigned B0_PAR = 0;
    localparam int unsigned B0_RST = 1;
    localparam int unsigned B0_UDC = 2;
    // status register 1 bit positions
    localparam int unsigned B1_HTH = 0;
    localparam int unsigned B1_GPT = 1;
    localparam int unsigned B1_STO = 2;

    typedef struct packed {
        logic [ST_W-1:0]   st0;
        logic [ST_W-1:0]   st1;
        logic [2*ST_W-1:0] mask;
    } ist_state_t;
endpackage

// File: rtl/scsi_ist_parity.sv
module scsi_ist_parity #(
    parameter int unsigned DATA_W = 8,
    parameter bit          ODD    = 1'b1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic              par_o
);
    generate
        if (ODD) begin : g_odd
            assign par_o = ~(^data_i);
        end else begin : g_even
            assign par_o = ^data_i;
        end
    endgenerate
endmodule

// File: rtl/scsi_ist_rst_edge.sv
module scsi_ist_rst_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], level_i};
        prev_d = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/scsi_int_status.sv
module scsi_int_status
    import scsi_ist_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              initiator_i,
    input  logic              low_level_i,
    input  logic              disc_evt_i,
    input  logic              disc_expected_i,
    input  logic              sel_timeout_i,
    input  logic              gp_timer_i,
    input  logic              hth_timer_i,
    input  logic              bus_rst_raw_i,
    input  logic              local_rst_i,
    input  logic              rx_strobe_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_par_i,
    input  logic              par_chk_en_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_par_o,
    input  logic              rd_stat0_i,
    input  logic              rd_stat1_i,
    input  logic              mask_wr_i,
    input  logic [2*ST_W-1:0] mask_wdata_i,
    output logic [ST_W-1:0]   status0_o,
    output logic [ST_W-1:0]   status1_o,
    output logic [2*ST_W-1:0] mask_o,
    output logic              irq_o
);
    localparam int unsigned MASK_W = 2 * ST_W;

    ist_state_t      st_d, st_q;
    logic            rst_rise;
    logic            rx_par_exp;
    logic            par_err;
    logic            udc_set;
    logic            report_ok;
    logic [ST_W-1:0] set0, set1;

    // one synchronizer serves both the external line and the local control
    scsi_ist_rst_edge #(.SYNC_STAGES(SYNC_STAGES)) u_rst_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (bus_rst_raw_i | local_rst_i),
        .rise_o  (rst_rise)
    );

    scsi_ist_parity #(.DATA_W(DATA_W), .ODD(1'b1)) u_rx_par (
        .data_i (rx_data_i),
        .par_o  (rx_par_exp)
    );

    scsi_ist_parity #(.DATA_W(DATA_W), .ODD(1'b1)) u_tx_par (
        .data_i (tx_data_i),
        .par_o  (tx_par_o)
    );

    always_comb begin
        // disconnects are reported in initiator or low-level mode only
        report_ok = initiator_i | low_level_i;
        udc_set   = report_ok & (sel_timeout_i |
                    (disc_evt_i & (low_level_i | ~disc_expected_i)));
        par_err   = rx_strobe_i & par_chk_en_i & (rx_par_i != rx_par_exp);

        set0         = '0;
        set0[B0_PAR] = par_err;
        set0[B0_RST] = rst_rise;
        set0[B0_UDC] = udc_set;

        set1         = '0;
        set1[B1_HTH] = hth_timer_i;
        set1[B1_GPT] = gp_timer_i;
        set1[B1_STO] = sel_timeout_i;

        st_d     = st_q;
        // clear on read, but a new event in the read cycle wins
        st_d.st0 = (st_q.st0 & ~{ST_W{rd_stat0_i}}) | set0;
        st_d.st1 = (st_q.st1 & ~{ST_W{rd_stat1_i}}) | set1;
        if (mask_wr_i) begin
            st_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status0_o = st_q.st0;
    assign status1_o = st_q.st1;
    assign mask_o    = st_q.mask;
    assign irq_o     = |({st_q.st1, st_q.st0} & st_q.mask[MASK_W-1:0]);
endmodule

// File: rtl/scsi_int_status_chk.sv
module scsi_int_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       initiator_i,
    input logic       low_level_i,
    input logic       sel_timeout_i,
    input logic       bus_rst_raw_i,
    input logic       local_rst_i,
    input logic       rx_strobe_i,
    input logic       par_chk_en_i,
    input logic [7:0] status0_o,
    input logic [7:0] status1_o
);
    AST_TGT_NO_UDC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status0_o[2]) |-> $past(initiator_i | low_level_i)); // R3

    AST_STO_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_timeout_i |=> status1_o[2]); // R5

    AST_STO_UDC: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_timeout_i && (initiator_i || low_level_i)) |=> status0_o[2]); // R5

    AST_RST_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status0_o[1]) |-> $past(bus_rst_raw_i | local_rst_i, 3)); // R6

    AST_PAR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status0_o[0]) |-> $past(rx_strobe_i && par_chk_en_i)); // R7

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status0_o[7:3] == 5'd0) && (status1_o[7:3] == 5'd0)); // R9
endmodule

bind scsi_int_status scsi_int_status_chk chk_i (.*);

// File: tb/scsi_int_status_tb_top.sv
`timescale 1ns/1ps
module scsi_int_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        initiator_i = 0, low_level_i = 0, disc_evt_i = 0, disc_expected_i = 0;
    logic        sel_timeout_i = 0, gp_timer_i = 0, hth_timer_i = 0;
    logic        bus_rst_raw_i = 0, local_rst_i = 0;
    logic        rx_strobe_i = 0, rx_par_i = 0, par_chk_en_i = 0;
    logic [7:0]  rx_data_i = 0, tx_data_i = 0;
    logic        tx_par_o;
    logic        rd_stat0_i = 0, rd_stat1_i = 0, mask_wr_i = 0;
    logic [15:0] mask_wdata_i = 0;
    logic [7:0]  status0_o, status1_o;
    logic [15:0] mask_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    scsi_int_status dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_all();
        rd_stat0_i = 1; rd_stat1_i = 1;
        tick();
        rd_stat0_i = 0; rd_stat1_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 st0", status0_o, 0);
        check("R1 st1", status1_o, 0);
        check("R1 mask", mask_o, 0);
        check("R1 irq", irq_o, 0);

        // R2 R3 R4: disconnect over every mode combination
        for (int m = 0; m < 8; m++) begin
            initiator_i = m[0]; low_level_i = m[1]; disc_expected_i = m[2];
            disc_evt_i = 1;
            tick();
            disc_evt_i = 0;
            check(m[1] ? "R4 disc" : (m[0] ? "R2 disc" : "R3 disc"),
                  status0_o[2], m[1] | (m[0] & ~m[2]));
            clear_all();
            check("R10 clear", status0_o, 0);
        end

        // R5 R3: selection time-out in every mode
        for (int m = 0; m < 4; m++) begin
            initiator_i = m[0]; low_level_i = m[1];
            sel_timeout_i = 1;
            tick();
            sel_timeout_i = 0;
            check("R5 sto", status1_o, 8'h04);
            check(m == 0 ? "R3 sto" : "R5 sto udc", status0_o[2], m[0] | m[1]);
            clear_all();
        end
        initiator_i = 1; low_level_i = 0;

        // R10: event in the read cycle is kept
        sel_timeout_i = 1; rd_stat1_i = 1; rd_stat0_i = 1;
        tick();
        sel_timeout_i = 0; rd_stat1_i = 0; rd_stat0_i = 0;
        check("R10 same-cycle st1", status1_o, 8'h04);
        check("R10 same-cycle st0", status0_o, 8'h04);
        clear_all();

        // R6: edge-detected bus reset
        bus_rst_raw_i = 1;
        tick(); tick();
        check("R6 not yet", status0_o[1], 0);
        tick();
        check("R6 set", status0_o[1], 1);
        clear_all();
        repeat (10) tick();
        check("R6 held once", status0_o[1], 0);
        bus_rst_raw_i = 0;
        repeat (4) tick();
        check("R6 release", status0_o[1], 0);
        local_rst_i = 1;
        repeat (3) tick();
        check("R6 local", status0_o[1], 1);
        local_rst_i = 0;
        repeat (4) tick();
        clear_all();

        // R7: exhaustive parity sweep
        for (int e = 0; e < 2; e++) begin
            for (int d = 0; d < 256; d++) begin
                for (int p = 0; p < 2; p++) begin
                    par_chk_en_i = e[0]; rx_data_i = d[7:0]; rx_par_i = p[0];
                    rx_strobe_i = 1;
                    tick();
                    rx_strobe_i = 0;
                    check("R7 parity", status0_o[0],
                          e[0] & ((($countones(d[7:0]) + p) % 2) == 0));
                    if (status0_o[0]) clear_all();
                end
            end
        end
        rx_data_i = 8'h00; rx_par_i = 0; par_chk_en_i = 1;
        tick();
        check("R7 no strobe", status0_o[0], 0);
        par_chk_en_i = 0;

        // R8: tx parity, with checking both off and on
        for (int d = 0; d < 512; d++) begin
            par_chk_en_i = d[8]; tx_data_i = d[7:0];
            #1;
            check("R8 txpar", tx_par_o, ($countones(d[7:0]) % 2) == 0);
        end
        par_chk_en_i = 0;
        tick();

        // R9: timer bits and reserved bits
        gp_timer_i = 1;
        tick();
        gp_timer_i = 0;
        check("R9 gp", status1_o, 8'h02);
        hth_timer_i = 1;
        tick();
        hth_timer_i = 0;
        check("R9 hth", status1_o, 8'h03);
        clear_all();

        // R10 R11: masked status visible, irq follows mask
        par_chk_en_i = 1; rx_data_i = 8'h00; rx_par_i = 0; rx_strobe_i = 1;
        gp_timer_i = 1;
        tick();
        rx_strobe_i = 0; gp_timer_i = 0; par_chk_en_i = 0;
        check("R10 masked st0", status0_o, 8'h01);
        check("R10 masked st1", status1_o, 8'h02);
        check("R11 irq masked", irq_o, 0);
        for (int b = 0; b < 17; b++) begin
            logic [15:0] mv;
            mv = (b < 16) ? (16'h1 << b) : 16'h0;
            mask_wdata_i = mv; mask_wr_i = 1;
            tick();
            mask_wr_i = 0;
            check("R11 mask", mask_o, mv);
            check("R11 irq", irq_o, mv[0] | mv[9]);
        end
        mask_wdata_i = 16'hFFFF; mask_wr_i = 1;
        tick();
        mask_wr_i = 0;
        rd_stat0_i = 1;
        tick();
        rd_stat0_i = 0;
        check("R11 irq st1 only", irq_o, 1);
        rd_stat1_i = 1;
        tick();
        rd_stat1_i = 0;
        check("R10 all clear irq", irq_o, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule